// File: doc/BRIEF.md
# SMBus Host Block-Data Buffer

This block is the byte store behind the block-data register of an SMBus host controller. Software loads it through one auto-incrementing register before a block write, and unloads it through the same register after a block read. The bus engine uses a separate port to take bytes out of the store while it transmits and to put bytes into it while it receives. Software and the engine share one byte index. Reading the host control register returns that index to zero.

A small register set surrounds the store. The control register exists for its read side effect. A count register carries the transfer length both ways: software writes it before a block write, and the engine loads it with the count the slave returned. An auxiliary register holds two mode bits, buffer enable and hardware CRC enable. When buffer mode is off, the block-data register is a single byte that reads back what was last written there. A count that is out of range raises an error flag and locks out further engine writes.

Top module: `smbus_block_buffer`

## Requirements
- R1: After reset every stored byte, the control, count and auxiliary registers, the error flag and the index are zero. tx_count, buf_mode, crc_mode and count_err are 0.
- R2: The auxiliary register is at host_sel=3. Bit 0 drives crc_mode and bit 1 drives buf_mode. A read returns the two bits as written (bit 1 reads 0 when BUF_PRESENT=0), with bits 7:2 reading zero.
- R3: A host read at host_sel=0 returns the last byte written there and sets the index to 0 on the next clock edge.
- R4: With buf_mode=1, a host write at host_sel=2 stores host_wdata at the current index. A host read at host_sel=2 returns the byte at the current index. Either access advances the index by one.
- R5: A host write at host_sel=1 loads the count register. eng_cnt_vld loads it from eng_cnt instead, and takes precedence over a host write in the same cycle. tx_count and host reads at host_sel=1 show the register.
- R6: Engine writes store eng_wdata at the shared index, and engine reads present the byte at that index on eng_rdata. Both advance the index when buf_mode=1. In a cycle with any engine access, a host access to host_sel=2 has no side effect.
- R7: The index stops at DEPTH-1. Accesses beyond that point all reach entry DEPTH-1, and entries 0 to DEPTH-2 keep their contents.
- R8: While xfer_busy=1, host writes at host_sel=2 neither store nor advance the index.
- R9: eng_cnt_vld with eng_cnt equal to 0 or above DEPTH sets count_err. While count_err=1, engine writes neither store nor advance. A host read at host_sel=0 clears count_err, and so does a count in range.
- R10: With buf_mode=0, every access at host_sel=2 and every engine access uses entry 0, and the index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 control, 1 count, 2 block data, 3 auxiliary |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (triggers side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected register |
| xfer_busy | input | 1 | Bus transaction in progress |
| eng_wr | input | 1 | Engine stores a received byte |
| eng_rd | input | 1 | Engine consumes a byte to transmit |
| eng_wdata | input | 8 | Byte received by the engine |
| eng_rdata | output | 8 | Byte at the current index, for the engine |
| eng_cnt_vld | input | 1 | Engine delivers a received byte count |
| eng_cnt | input | 8 | Received byte count |
| tx_count | output | 8 | Count register contents |
| buf_mode | output | 1 | Buffer mode enabled |
| crc_mode | output | 1 | Hardware CRC enabled |
| count_err | output | 1 | Out-of-range received count flag |

## Verification
The bench overfills the store past DEPTH and reads it all back. A design that wraps its index would show the first entries overwritten, and one that runs past the end would show entry DEPTH-1 stale. Host writes are aimed at the block-data register during busy cycles and during cycles with engine traffic. A design that lets them through would show an extra byte or a shifted index on readback. Counts of 0 and of 40 are sent, followed by engine writes. A design that misses the error would store those bytes and move the index. With buffer mode off, repeated accesses must all land on entry 0; a design that still advanced the index would return data from the wrong entry after buffer mode is enabled again.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    localparam int BYTE_W  = 8;
    localparam int AUX_CRC = 0;
    localparam int AUX_BUF = 1;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_BLOCK = 2'd2,
        REG_AUX   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] count;
        logic [1:0]        aux;
        logic              err;
    } regs_t;
endpackage

// File: rtl/smbb_index.sv
module smbb_index #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr)
            idx_d = '0;
        else if (step && (idx_q != LAST))
            idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (waddr == IDX_W'(i)))
                ent_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent[i] = ent_q;
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/smbus_block_buffer.sv
module smbus_block_buffer
    import smbb_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int BUF_PRESENT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              xfer_busy,
    input  logic              eng_wr,
    input  logic              eng_rd,
    input  logic [BYTE_W-1:0] eng_wdata,
    output logic [BYTE_W-1:0] eng_rdata,
    input  logic              eng_cnt_vld,
    input  logic [BYTE_W-1:0] eng_cnt,
    output logic [BYTE_W-1:0] tx_count,
    output logic              buf_mode,
    output logic              crc_mode,
    output logic              count_err
);
    localparam int   IDX_W      = $clog2(DEPTH);
    localparam logic BUF_ALLOW  = (BUF_PRESENT != 0);
    localparam logic [BYTE_W:0] CNT_MAX = (BYTE_W+1)'(DEPTH);

    regs_t r_d, r_q;

    logic             eng_act, host_blk_wr, host_blk_rd, eng_wr_ok;
    logic             idx_clr, idx_step, cnt_bad;
    logic [IDX_W-1:0] blk_idx, acc_addr;
    logic [BYTE_W-1:0] rd_byte, st_wdata;

    // engine access wins; busy locks host block writes
    assign eng_act     = eng_wr | eng_rd;
    assign host_blk_wr = host_wr && (host_sel == REG_BLOCK) && !xfer_busy && !eng_act;
    assign host_blk_rd = host_rd && (host_sel == REG_BLOCK) && !eng_act;
    assign eng_wr_ok   = eng_wr && !r_q.err;
    assign idx_clr     = host_rd && (host_sel == REG_CTRL);
    assign idx_step    = r_q.aux[AUX_BUF] &&
                         (host_blk_wr || host_blk_rd || eng_wr_ok || eng_rd);
    assign cnt_bad     = (eng_cnt == '0) || ({1'b0, eng_cnt} > CNT_MAX);
    assign acc_addr    = r_q.aux[AUX_BUF] ? blk_idx : '0;
    assign st_wdata    = eng_wr ? eng_wdata : host_wdata;

    smbb_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .step  (idx_step),
        .idx   (blk_idx)
    );

    smbb_store #(.DEPTH(DEPTH), .W(BYTE_W), .IDX_W(IDX_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_blk_wr || eng_wr_ok),
        .waddr (acc_addr),
        .wdata (st_wdata),
        .raddr (acc_addr),
        .rdata (rd_byte)
    );

    always_comb begin
        r_d = r_q;
        if (host_wr) begin
            unique case (reg_sel_e'(host_sel))
                REG_CTRL:  r_d.ctrl = host_wdata;
                REG_COUNT: r_d.count = host_wdata;
                REG_AUX: begin
                    r_d.aux[AUX_CRC] = host_wdata[AUX_CRC];
                    r_d.aux[AUX_BUF] = host_wdata[AUX_BUF] & BUF_ALLOW;
                end
                default: ;
            endcase
        end
        if (idx_clr)
            r_d.err = 1'b0;
        if (eng_cnt_vld) begin
            r_d.count = eng_cnt;
            r_d.err   = cnt_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (reg_sel_e'(host_sel))
            REG_CTRL:  host_rdata = r_q.ctrl;
            REG_COUNT: host_rdata = r_q.count;
            REG_BLOCK: host_rdata = rd_byte;
            default:   host_rdata = {{(BYTE_W-2){1'b0}}, r_q.aux};
        endcase
    end

    assign eng_rdata = rd_byte;
    assign tx_count  = r_q.count;
    assign buf_mode  = r_q.aux[AUX_BUF];
    assign crc_mode  = r_q.aux[AUX_CRC];
    assign count_err = r_q.err;
endmodule

// File: rtl/smbb_checker.sv
module smbb_checker #(
    parameter int DEPTH       = 32,
    parameter int BUF_PRESENT = 1,
    parameter int IDX_W       = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic [7:0]       host_wdata,
    input logic             xfer_busy,
    input logic             eng_wr,
    input logic             eng_rd,
    input logic             eng_cnt_vld,
    input logic [7:0]       eng_cnt,
    input logic [7:0]       tx_count,
    input logic             buf_mode,
    input logic             crc_mode,
    input logic             count_err,
    input logic [IDX_W-1:0] idx_q
);
    logic ctrl_rd;
    assign ctrl_rd = host_rd && (host_sel == 2'd0);

    // R3
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (idx_q == '0));

    // R2
    aux_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |=> (crc_mode == $past(host_wdata[0])));

    // R2
    aux_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |=>
            (buf_mode == ($past(host_wdata[1]) && (BUF_PRESENT != 0))));

    // R5
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cnt_vld |=> (tx_count == $past(eng_cnt)));

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_q == IDX_W'(DEPTH - 1)) && !ctrl_rd) |=> (idx_q == IDX_W'(DEPTH - 1)));

    // R8
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2 && xfer_busy && !eng_wr && !eng_rd && !host_rd)
            |=> $stable(idx_q));

    // R9
    bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cnt_vld && (eng_cnt == 8'd0 || eng_cnt > 8'(DEPTH))) |=> count_err);

    // R9
    err_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_err && eng_wr && !ctrl_rd) |=> $stable(idx_q));

    // R10
    pass_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && !ctrl_rd) |=> $stable(idx_q));
endmodule

bind smbus_block_buffer smbb_checker #(
    .DEPTH(DEPTH), .BUF_PRESENT(BUF_PRESENT), .IDX_W(IDX_W)
) i_smbb_checker (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .xfer_busy(xfer_busy),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_cnt_vld(eng_cnt_vld),
    .eng_cnt(eng_cnt), .tx_count(tx_count), .buf_mode(buf_mode),
    .crc_mode(crc_mode), .count_err(count_err), .idx_q(blk_idx)
);

// File: tb/test_smbus_block_buffer.sv
`timescale 1ns/1ps
module test_smbus_block_buffer;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic       host_wr = 0, host_rd = 0, xfer_busy = 0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       eng_wr = 0, eng_rd = 0, eng_cnt_vld = 0;
    logic [7:0] eng_wdata = '0, eng_rdata, eng_cnt = '0, tx_count;
    logic       buf_mode, crc_mode, count_err;

    always #4 clk = ~clk;

    smbus_block_buffer #(.DEPTH(DEPTH), .BUF_PRESENT(1)) i_smbus_block_buffer (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_busy(xfer_busy), .eng_wr(eng_wr), .eng_rd(eng_rd),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_cnt_vld(eng_cnt_vld),
        .eng_cnt(eng_cnt), .tx_count(tx_count), .buf_mode(buf_mode),
        .crc_mode(crc_mode), .count_err(count_err)
    );

    // reference state, built from the requirements
    logic [7:0] m_mem [DEPTH];
    int         m_idx;
    logic [7:0] m_count, m_ctrl;
    logic [1:0] m_aux;
    logic       m_err;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] sel);
        int a = m_aux[1] ? m_idx : 0;
        case (sel)
            2'd0:    return m_ctrl;
            2'd1:    return m_count;
            2'd2:    return m_mem[a];
            default: return {6'b0, m_aux};
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_idx = 0; m_count = '0; m_ctrl = '0; m_aux = '0; m_err = 0;
    endtask

    task automatic cyc(input bit hw, input bit hr, input logic [1:0] sel,
                       input logic [7:0] wd, input bit busy, input bit ew,
                       input bit er, input logic [7:0] ewd, input bit cv,
                       input logic [7:0] cnt, input string tag);
        int  a;
        bit  eact, hbw, hbr, ewok, clr;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_sel = sel; host_wdata = wd;
        xfer_busy = busy; eng_wr = ew; eng_rd = er; eng_wdata = ewd;
        eng_cnt_vld = cv; eng_cnt = cnt;
        #1;
        chk({tag, " R5 tx_count"}, tx_count, m_count);
        chk({tag, " R2 modes"}, {6'b0, buf_mode, crc_mode}, {6'b0, m_aux});
        chk({tag, " R9 count_err"}, {7'b0, count_err}, {7'b0, m_err});
        if (hr) chk({tag, " host_rdata"}, host_rdata, exp_rdata(sel));
        a = m_aux[1] ? m_idx : 0;
        if (er) chk({tag, " R6 eng_rdata"}, eng_rdata, m_mem[a]);
        // model update for the coming edge
        eact = ew || er;
        hbw  = hw && sel == 2'd2 && !busy && !eact;
        hbr  = hr && sel == 2'd2 && !eact;
        ewok = ew && !m_err;
        clr  = hr && sel == 2'd0;
        if (hbw)  m_mem[a] = wd;
        if (ewok) m_mem[a] = ewd;
        if (clr) m_idx = 0;
        else if (m_aux[1] && (hbw || hbr || ewok || er) && m_idx < DEPTH - 1) m_idx++;
        if (hw && sel == 2'd0) m_ctrl = wd;
        if (hw && sel == 2'd1) m_count = wd;
        if (hw && sel == 2'd3) m_aux = wd[1:0];
        if (clr) m_err = 0;
        if (cv) begin
            m_count = cnt;
            m_err = (cnt == 0) || (cnt > DEPTH);
        end
    endtask

    task automatic hwr(input logic [1:0] sel, input logic [7:0] d, input string t);
        cyc(1, 0, sel, d, 0, 0, 0, 0, 0, 0, t);
    endtask
    task automatic hrd(input logic [1:0] sel, input string t);
        cyc(0, 1, sel, 0, 0, 0, 0, 0, 0, 0, t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
        hrd(2'd3, "R1 aux");
        hrd(2'd2, "R1 block");
        hrd(2'd1, "R1 count");
        // R2 enable buffer and crc
        hwr(2'd3, 8'hFF, "R2 set");
        hrd(2'd3, "R2 readback");
        hwr(2'd3, 8'h02, "R2 buf only");
        // R5 count
        hwr(2'd1, 8'd5, "R5 host count");
        hrd(2'd1, "R5 readback");
        cyc(1, 0, 2'd1, 8'd9, 0, 0, 0, 0, 1, 8'd7, "R5 engine wins");
        // R3 and R4, R7 overfill
        hwr(2'd0, 8'hA5, "R3 ctrl write");
        hrd(2'd0, "R3 ctrl read");
        for (int i = 0; i < DEPTH + 3; i++) hwr(2'd2, 8'h40 + 8'(i), "R7 fill");
        hrd(2'd0, "R3 rewind");
        for (int i = 0; i < DEPTH + 2; i++) hrd(2'd2, "R4 R7 drain");
        // R8 busy lock
        hrd(2'd0, "R3 rewind");
        for (int i = 0; i < 4; i++) cyc(1, 0, 2'd2, 8'hEE, 1, 0, 0, 0, 0, 0, "R8 busy");
        hrd(2'd2, "R8 entry0");
        hrd(2'd2, "R8 entry1");
        // R6 engine side and priority
        hrd(2'd0, "R3 rewind");
        cyc(0, 0, 0, 0, 1, 1, 0, 8'hC1, 0, 0, "R6 eng wr");
        cyc(1, 0, 2'd2, 8'h77, 1, 1, 0, 8'hC2, 0, 0, "R6 eng wr with host");
        cyc(1, 0, 2'd2, 8'h66, 0, 0, 1, 0, 0, 0, "R6 eng rd with host");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd3, "R6 count");
        hrd(2'd0, "R3 rewind");
        for (int i = 0; i < 4; i++) hrd(2'd2, "R6 readback");
        // R9 bad counts
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd0, "R9 zero");
        hrd(2'd0, "R9 clear");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd40, "R9 forty");
        cyc(0, 0, 0, 0, 1, 1, 0, 8'hBB, 0, 0, "R9 locked wr");
        cyc(0, 0, 0, 0, 1, 1, 0, 8'hBC, 0, 0, "R9 locked wr");
        hrd(2'd2, "R9 entry0");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'd32, "R9 valid count");
        // R10 pass-through
        hwr(2'd3, 8'h00, "R10 off");
        hwr(2'd2, 8'h99, "R10 write");
        hwr(2'd2, 8'h9A, "R10 write");
        hrd(2'd2, "R10 read");
        hrd(2'd2, "R10 read");
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R10 eng rd");
        hwr(2'd3, 8'h02, "R10 back on");
        hrd(2'd2, "R10 idx kept");
        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int   k    = $urandom % 8;
            logic [1:0] sel = 2'($urandom % 4);
            bit   busy = ($urandom % 4) == 0;
            bit   side = ($urandom % 8) == 0;
            logic [7:0] d = 8'($urandom);
            logic [7:0] c = 8'($urandom % 48);
            case (k)
                0, 1: cyc(1, 0, sel, d, busy, side, 0, d ^ 8'h5A, 0, 0, "R4 rnd wr");
                2, 3: cyc(0, 1, sel, 0, busy, 0, side, 0, 0, 0, "R4 rnd rd");
                4:    cyc(0, 0, 0, 0, busy, 1, 0, d, 0, 0, "R6 rnd ewr");
                5:    cyc(0, 0, 0, 0, busy, 0, 1, 0, 0, 0, "R6 rnd erd");
                6:    cyc(0, 0, 0, 0, busy, 0, 0, 0, 1, c, "R9 rnd cnt");
                default: cyc(0, 0, 0, 0, busy, 0, 0, 0, 0, 0, "R7 rnd idle");
            endcase
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "end");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule